// File: doc/BRIEF.md
# Lockable Extended Register Bank with Single-Bank Address Translation

This block is the extended-register file of a VGA-class graphics controller. A host reaches it through an index/data pair. It presents the index on `reg_idx`. It reads the data port combinationally on `reg_rdata`, and it writes with a single-cycle `reg_wr` strobe. One index holds a key. The key's low three bits decide whether the other extended indexes are reachable. When they are not reachable, those indexes read as zero and ignore writes.

The stored values feed other parts of the controller directly:
- The first bank offset, in 4 KiB units, is added to the CPU's offset inside the graphics window. The result is the video-memory address, wrapped to the installed memory size.
- Two bits of the CRT-control register become the top bits of the display start and cursor start addresses.
- The pixel-clock select is taken from the clock field of the miscellaneous output register.
- The dual-bank enable bit is passed out as a flag only. Translation always uses single-bank mode.

The memory size comes from a static strap input, and the memory-configuration index reports it.

Top module: `xrb_top`

## Requirements
- R1: After reset, index 0x0F reads 0x05. Indexes 0x09, 0x0A, 0x0C, 0x0D and 0x0E read 0x00. Index 0x0B reads the strap in bits [7:6] with bit 3 clear. `dual_bank_en`, `disp_start_hi` and `cursor_start_hi` are 0.
- R2: Index 0x0F (key) stores all 8 written bits and reads them back, whatever the lock state.
- R3: The bank is unlocked exactly when key bits [2:0] equal 3'b101. Key bits [7:3] have no influence on the lock state.
- R4: While locked, reads of indexes 0x09–0x0E return 0x00 and writes to them leave every register unchanged.
- R5: An index outside 0x09–0x0F reads 0x00, and a write to it changes no register and no output.
- R6: Index 0x0B reads {strap[1:0], 2'b00, dual, 3'b000}. The strap encodes memory size as 2'b01 = 256 KiB, 2'b10 = 512 KiB and 2'b11 = 1 MiB. A write changes only bit 3.
- R7: `dual_bank_en` equals bit 3 of index 0x0B.
- R8: `vid_addr` = (bank A value at index 0x09 × 4096 + `cpu_off`) modulo the strapped memory size. All 8 bank bits are used, and strap 2'b00 is treated as 256 KiB. The value at index 0x0A does not affect the address.
- R9: `disp_start_hi` and `cursor_start_hi` both equal bits [4:3] of index 0x0D.
- R10: `pclk_sel` equals bits [3:2] of `misc_out_reg`.
- R11: While unlocked, indexes 0x09, 0x0A, 0x0C, 0x0D and 0x0E store and return all 8 written bits.
- R12: `reg_rdata` follows `reg_idx` and register contents within the same cycle. A write becomes visible only after the rising edge on which `reg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_size_strap | input | 2 | Static memory-size strap |
| reg_idx | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the indexed register |
| misc_out_reg | input | 8 | Miscellaneous output register value |
| cpu_off | input | 16 | CPU byte offset inside the graphics window |
| vid_addr | output | 20 | Translated video-memory byte address |
| dual_bank_en | output | 1 | Dual-bank request flag |
| disp_start_hi | output | 2 | Display start address bits [17:16] |
| cursor_start_hi | output | 2 | Cursor start address bits [17:16] |
| pclk_sel | output | 2 | Pixel-clock source select |

## Verification
The checker watches several properties on every cycle:
- locked and out-of-range indexes read zero, and writes to them leave the register state untouched;
- key writes always land;
- the memory-configuration read-back keeps its fixed fields;
- the dual-bank and CRT bits follow their writes one edge later;
- the address never exceeds the strapped size.

Only the bench's sweeps show the rest:
- the full lock decode across all 256 key values;
- the exact arithmetic of the address translation for every bank value and strap;
- that a write is invisible until its clock edge.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 8;

  localparam logic [IDX_W-1:0] IDX_BANK_A = 8'h09;
  localparam logic [IDX_W-1:0] IDX_BANK_B = 8'h0A;
  localparam logic [IDX_W-1:0] IDX_MEMCFG = 8'h0B;
  localparam logic [IDX_W-1:0] IDX_VCFG   = 8'h0C;
  localparam logic [IDX_W-1:0] IDX_CRT    = 8'h0D;
  localparam logic [IDX_W-1:0] IDX_VCTL   = 8'h0E;
  localparam logic [IDX_W-1:0] IDX_KEY    = 8'h0F;

  localparam logic [DATA_W-1:0] KEY_RESET   = 8'h05;
  localparam logic [2:0]        UNLOCK_CODE = 3'b101;
  localparam int                DUAL_BIT    = 3;
  localparam int                CRT_HI_LSB  = 3;

  typedef struct packed {
    logic [DATA_W-1:0] key;
    logic [DATA_W-1:0] bank_a;
    logic [DATA_W-1:0] bank_b;
    logic              dual;
    logic [DATA_W-1:0] vcfg;
    logic [DATA_W-1:0] crt;
    logic [DATA_W-1:0] vctl;
  } xrb_regs_t;
endpackage

// File: rtl/xrb_rst_sync.sv
module xrb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xrb_regfile.sv
module xrb_regfile
  import xrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mem_size,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output xrb_regs_t         regs
);
  xrb_regs_t regs_q, regs_d;
  logic      unlocked;

  assign unlocked = (regs_q.key[2:0] == UNLOCK_CODE);

  // next-state
  always_comb begin
    regs_d = regs_q;
    if (idx == IDX_KEY) begin
      regs_d.key = wdata;
    end else if (unlocked) begin
      case (idx)
        IDX_BANK_A: regs_d.bank_a = wdata;
        IDX_BANK_B: regs_d.bank_b = wdata;
        IDX_MEMCFG: regs_d.dual   = wdata[DUAL_BIT];
        IDX_VCFG:   regs_d.vcfg   = wdata;
        IDX_CRT:    regs_d.crt    = wdata;
        IDX_VCTL:   regs_d.vctl   = wdata;
        default:    regs_d        = regs_q;
      endcase
    end
  end

  // state, clock enable on the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q.key    <= KEY_RESET;
      regs_q.bank_a <= '0;
      regs_q.bank_b <= '0;
      regs_q.dual   <= 1'b0;
      regs_q.vcfg   <= '0;
      regs_q.crt    <= '0;
      regs_q.vctl   <= '0;
    end else if (wr) begin
      regs_q <= regs_d;
    end
  end

  // combinational read mux
  always_comb begin
    rdata = '0;
    if (idx == IDX_KEY) begin
      rdata = regs_q.key;
    end else if (unlocked) begin
      case (idx)
        IDX_BANK_A: rdata = regs_q.bank_a;
        IDX_BANK_B: rdata = regs_q.bank_b;
        IDX_MEMCFG: rdata = {mem_size, 2'b00, regs_q.dual, 3'b000};
        IDX_VCFG:   rdata = regs_q.vcfg;
        IDX_CRT:    rdata = regs_q.crt;
        IDX_VCTL:   rdata = regs_q.vctl;
        default:    rdata = '0;
      endcase
    end
  end

  assign regs = regs_q;
endmodule

// File: rtl/xrb_addr_xlate.sv
module xrb_addr_xlate #(
  parameter int BANK_W  = 8,
  parameter int GRAN_LG = 12,
  parameter int OFF_W   = 16,
  parameter int ADDR_W  = 20
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  cpu_off,
  input  logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] vid_addr
);
  localparam int BASE_W = BANK_W + GRAN_LG;
  localparam int SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

  logic [SUM_W-1:0]  base_w, off_w, sum_w;
  logic [ADDR_W-1:0] size_mask;

  assign base_w = SUM_W'(bank) << GRAN_LG;
  assign off_w  = SUM_W'(cpu_off);
  assign sum_w  = base_w + off_w;

  // largest size fills ADDR_W bits; each smaller code halves it
  always_comb begin
    case (mem_size)
      2'b11:   size_mask = {ADDR_W{1'b1}};
      2'b10:   size_mask = {ADDR_W{1'b1}} >> 1;
      default: size_mask = {ADDR_W{1'b1}} >> 2;
    endcase
  end

  assign vid_addr = sum_w[ADDR_W-1:0] & size_mask;
endmodule

// File: rtl/xrb_top.sv
module xrb_top
  import xrb_pkg::*;
#(
  parameter int OFF_W   = 16,
  parameter int ADDR_W  = 20,
  parameter int GRAN_LG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mem_size_strap,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [7:0]        misc_out_reg,
  input  logic [OFF_W-1:0]  cpu_off,
  output logic [ADDR_W-1:0] vid_addr,
  output logic              dual_bank_en,
  output logic [1:0]        disp_start_hi,
  output logic [1:0]        cursor_start_hi,
  output logic [1:0]        pclk_sel
);
  logic      rst_q_n;
  xrb_regs_t regs_q;

  xrb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  xrb_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .mem_size (mem_size_strap),
    .idx      (reg_idx),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .regs     (regs_q)
  );

  xrb_addr_xlate #(
    .BANK_W  (DATA_W),
    .GRAN_LG (GRAN_LG),
    .OFF_W   (OFF_W),
    .ADDR_W  (ADDR_W)
  ) u_xlate (
    .bank     (regs_q.bank_a),
    .cpu_off  (cpu_off),
    .mem_size (mem_size_strap),
    .vid_addr (vid_addr)
  );

  assign dual_bank_en    = regs_q.dual;
  assign disp_start_hi   = regs_q.crt[CRT_HI_LSB +: 2];
  assign cursor_start_hi = regs_q.crt[CRT_HI_LSB +: 2];
  assign pclk_sel        = misc_out_reg[3:2];
endmodule

// File: rtl/xrb_checker.sv
module xrb_checker
  import xrb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mem_size_strap,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [7:0]        misc_out_reg,
  input logic [ADDR_W-1:0] vid_addr,
  input logic              dual_bank_en,
  input logic [1:0]        disp_start_hi,
  input logic [1:0]        pclk_sel,
  input xrb_regs_t         regs
);
  logic locked, in_lock_rng, out_rng;
  assign locked      = (regs.key[2:0] != UNLOCK_CODE);
  assign in_lock_rng = (reg_idx >= IDX_BANK_A) && (reg_idx <= IDX_VCTL);
  assign out_rng     = (reg_idx < IDX_BANK_A) || (reg_idx > IDX_KEY);

  p_key_rw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_KEY) |=> (regs.key == $past(reg_wdata)));

  p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && in_lock_rng) |-> (reg_rdata == '0));

  p_locked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && locked && in_lock_rng) |=> $stable(regs));

  p_oor_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_rng |-> (reg_rdata == '0));

  p_oor_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && out_rng) |=> $stable(regs));

  p_memcfg_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && reg_idx == IDX_MEMCFG) |->
      (reg_rdata[7:6] == mem_size_strap && reg_rdata[5:4] == 2'b00 && reg_rdata[2:0] == 3'b000));

  p_dual_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !locked && reg_idx == IDX_MEMCFG) |=> (dual_bank_en == $past(reg_wdata[DUAL_BIT])));

  p_addr_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_size_strap != 2'b11) |-> (vid_addr[ADDR_W-1] == 1'b0));

  p_crt_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !locked && reg_idx == IDX_CRT) |=> (disp_start_hi == $past(reg_wdata[4:3])));

  p_pclk_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(misc_out_reg) |-> $stable(pclk_sel));
endmodule

bind xrb_top xrb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_q_n),
  .mem_size_strap (mem_size_strap),
  .reg_idx        (reg_idx),
  .reg_wr         (reg_wr),
  .reg_wdata      (reg_wdata),
  .reg_rdata      (reg_rdata),
  .misc_out_reg   (misc_out_reg),
  .vid_addr       (vid_addr),
  .dual_bank_en   (dual_bank_en),
  .disp_start_hi  (disp_start_hi),
  .pclk_sel       (pclk_sel),
  .regs           (regs_q)
);

// File: tb/test_xrb_top.sv
module test_xrb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  strap;
  logic [7:0]  reg_idx, reg_wdata, reg_rdata, misc;
  logic        reg_wr;
  logic [15:0] cpu_off;
  logic [19:0] vid_addr;
  logic        dual_bank_en;
  logic [1:0]  disp_hi, curs_hi, pclk_sel;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  // bench model
  logic [7:0] m_key, m_ba, m_bb, m_vcfg, m_crt, m_vctl;
  logic       m_dual;

  always #(CLK_PERIOD/2) clk = ~clk;

  xrb_top i_xrb_top (
    .clk(clk), .rst_n(rst_n), .mem_size_strap(strap),
    .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .misc_out_reg(misc), .cpu_off(cpu_off), .vid_addr(vid_addr),
    .dual_bank_en(dual_bank_en), .disp_start_hi(disp_hi),
    .cursor_start_hi(curs_hi), .pclk_sel(pclk_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_unl();
    return m_key[2:0] == 3'b101;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] i);
    if (i == 8'h0F) return m_key;
    if (i < 8'h09 || i > 8'h0F || !m_unl()) return 8'h00;
    case (i)
      8'h09:   return m_ba;
      8'h0A:   return m_bb;
      8'h0B:   return {strap, 2'b00, m_dual, 3'b000};
      8'h0C:   return m_vcfg;
      8'h0D:   return m_crt;
      default: return m_vctl;
    endcase
  endfunction

  function automatic string tag_for(input logic [7:0] i);
    if (i == 8'h0F) return "R2";
    if (i < 8'h09 || i > 8'h0F) return "R5";
    if (!m_unl()) return "R4";
    if (i == 8'h0B) return "R6";
    return "R11";
  endfunction

  task automatic model_wr(input logic [7:0] i, input logic [7:0] d);
    if (i == 8'h0F) m_key = d;
    else if (m_unl()) begin
      case (i)
        8'h09: m_ba = d;
        8'h0A: m_bb = d;
        8'h0B: m_dual = d[3];
        8'h0C: m_vcfg = d;
        8'h0D: m_crt = d;
        8'h0E: m_vctl = d;
        default: ;
      endcase
    end
  endtask

  task automatic do_wr(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk);
    reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(i, d);
  endtask

  task automatic chk_rd(input logic [7:0] i, input string tag);
    @(negedge clk);
    reg_idx = i;
    #1;
    check(tag, {24'd0, reg_rdata}, {24'd0, exp_rd(i)});
  endtask

  task automatic chk_outs();
    check("R7 dual_bank_en", {31'd0, dual_bank_en}, {31'd0, m_dual});
    check("R9 disp_start_hi", {30'd0, disp_hi}, {30'd0, m_crt[4:3]});
    check("R9 cursor_start_hi", {30'd0, curs_hi}, {30'd0, m_crt[4:3]});
  endtask

  initial begin
    rst_n = 1'b0; strap = 2'b10; reg_idx = '0; reg_wdata = '0; reg_wr = 1'b0;
    misc = '0; cpu_off = '0;
    m_key = 8'h05; m_ba = '0; m_bb = '0; m_vcfg = '0; m_crt = '0; m_vctl = '0; m_dual = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int i = 9; i <= 15; i++) chk_rd(8'(i), "R1 reset read");
    check("R1 reset dual", {31'd0, dual_bank_en}, 32'd0);
    check("R1 reset disp_hi", {30'd0, disp_hi}, 32'd0);

    // R12: write invisible before its edge, visible after
    @(negedge clk);
    reg_idx = 8'h09; reg_wdata = 8'hC3; reg_wr = 1'b1;
    #1;
    check("R12 before edge", {24'd0, reg_rdata}, 32'h00);
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(8'h09, 8'hC3);
    #1;
    check("R12 after edge", {24'd0, reg_rdata}, 32'hC3);

    // R2/R3/R4: full key sweep
    for (int k = 0; k < 256; k++) begin
      do_wr(8'h0F, 8'(k));
      chk_rd(8'h0F, "R2 key readback");
      do_wr(8'h09, ~8'(k));
      chk_rd(8'h09, ((k & 7) == 5) ? "R3 unlocked read" : "R4 locked read");
      do_wr(8'h0F, 8'h05);
      chk_rd(8'h09, "R3 value after unlock");
    end

    // R4/R5/R6/R7/R9/R11: index sweep, unlocked and locked passes
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 256; i++) begin
        do_wr(8'h0F, (p == 0) ? 8'h05 : 8'hF8);
        do_wr(8'(i), 8'(i) ^ 8'h3C ^ 8'(p * 8'h99));
        chk_rd(8'(i), tag_for(8'(i)));
        for (int j = 9; j <= 15; j++) chk_rd(8'(j), tag_for(8'(j)));
        chk_outs();
      end
    end

    // R6: strap read-back for each size code
    do_wr(8'h0F, 8'h05);
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      chk_rd(8'h0B, "R6 strap field");
    end

    // R10: misc clock field sweep
    for (int m = 0; m < 256; m++) begin
      @(negedge clk);
      misc = 8'(m);
      #1;
      check("R10 pclk_sel", {30'd0, pclk_sel}, {30'd0, 2'(m >> 2)});
    end

    // R8: address translation sweep (bank B set to a distractor value)
    do_wr(8'h0A, 8'h77);
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int b = 0; b < 256; b++) begin
        do_wr(8'h09, 8'(b));
        for (int o = 0; o < 4; o++) begin
          logic [31:0] off, e, mask;
          case (o)
            0: off = 32'h0000;
            1: off = 32'hFFFF;
            2: off = 32'h0ABC;
            default: off = (b * 257) & 32'hFFFF;
          endcase
          mask = (s == 3) ? 32'hFFFFF : (s == 2) ? 32'h7FFFF : 32'h3FFFF;
          e = ((b << 12) + off) & mask;
          cpu_off = off[15:0];
          #1;
          check("R8 vid_addr", {12'd0, vid_addr}, e);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule